// File: doc/BRIEF.md
# Contour Moment Accumulator Unit

This block takes the boundary pixels of one contour at a time as a stream of (x, y) coordinates and reduces them to the figures an ellipse fitter starts from: the pixel count, the centroid, and the three second-order central moments. While the coordinates arrive it keeps only running sums: the count, the sums of x and y, and the sums of x squared, y squared and x times y. Per pixel this costs additions and multiplications and nothing else, so no pixel is stored and there is no second pass.

A separate marker beat closes the contour. Its arrival starts a fixed post-processing sequence. One shared divider, which produces one quotient bit per clock, forms the five averages (mean x, mean y, mean of x squared, mean of y squared, mean of x times y) in that order. A squaring stage then multiplies the stored means once. A final stage subtracts each squared mean from the matching mean of squares. The work after the marker does not depend on the contour length. Every contour is handled independently of the ones before it.

Both streams use valid/ready. An input beat is taken on a clock edge where in_valid and in_ready are both high. in_ready stays low from the moment a non-empty contour is closed until its result has been taken, so the producer simply waits. The result holds steady while out_valid is high and out_ready is low. It is consumed on the edge where both are high.

Top module: `contour_moment_unit`

## Requirements
- R1: in_ready is high after reset and whenever no contour is being finished. It goes low on the clock after a marker closes a non-empty contour, and stays low until the result handshake. It returns high on the clock after that handshake, so a result waiting on out_valid never coexists with in_ready high.
- R2: A beat with in_last = 1 is a marker only. Its in_x and in_y values are ignored and it is not counted as a pixel.
- R3: out_count equals the number of coordinate beats since the previous marker. The sums restart with the first coordinate beat after a marker, so no value from an earlier contour leaks into a later one.
- R4: out_mean_x = floor(Σx·256/n) and out_mean_y = floor(Σy·256/n). Both are unsigned, with 8 fractional bits.
- R5: out_mxx = floor(Σx²·256/n) − floor(out_mean_x²/256), and out_myy is formed the same way from y. Both are unsigned, with 8 fractional bits, and never negative.
- R6: out_mxy = floor(Σxy·256/n) − floor(out_mean_x·out_mean_y/256). It is two's complement, with 8 fractional bits.
- R7: A contour of exactly one pixel yields out_mxx = out_myy = out_mxy = 0.
- R8: A marker with no coordinate beat before it (n = 0) is consumed, produces no result, and leaves in_ready high.
- R9: out_valid rises exactly 5·(D+2)+2 clock edges after the edge that accepts the closing marker, where D = 2·max(XW,YW)+NW+FRAC. With the default parameters this is 227 edges, independent of n.
- R10: While out_valid is high and out_ready is low, out_valid and every result port hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_x | input | XW (9) | Pixel column, unsigned |
| in_y | input | YW (8) | Pixel row, unsigned |
| in_last | input | 1 | Beat is the end-of-contour marker |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_count | output | NW (17) | Pixel count n |
| out_mean_x | output | XW+FRAC (17) | Mean x, 8 fractional bits |
| out_mean_y | output | YW+FRAC (16) | Mean y, 8 fractional bits |
| out_mxx | output | 2·XW+FRAC (26) | Central moment in x, unsigned |
| out_myy | output | 2·YW+FRAC (24) | Central moment in y, unsigned |
| out_mxy | output | XW+YW+FRAC+1 (26) | Cross moment, two's complement |

## Verification
The assertions assume that no contour holds more than 2^NW − 1 coordinate beats. They also assume the producer obeys valid/ready, so input values only matter on an accepted beat. The stimulus keeps every contour to a few hundred beats and every coordinate inside the frame. It mixes random contours, single-pixel contours, repeated-point contours, empty markers and contours at the frame's far corner, and it puts random coordinates on marker beats. Random gaps on the input and random back-pressure on the output exercise the stall and hold rules while the bench model tracks ready, valid and the latency on every clock.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [2:0] {
    ST_ACC,
    ST_DIV,
    ST_SQ,
    ST_SUB,
    ST_OUT
  } cmu_state_t;

  localparam int unsigned NUM_DIV = 5;
endpackage

// File: rtl/cmu_accum.sv
module cmu_accum #(
  parameter int XW = 9,
  parameter int YW = 8,
  parameter int NW = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat_i,
  input  logic                   clr_i,
  input  logic [XW-1:0]          x_i,
  input  logic [YW-1:0]          y_i,
  output logic                   empty_o,
  output logic [NW-1:0]          n_o,
  output logic [XW+NW-1:0]       sx_o,
  output logic [YW+NW-1:0]       sy_o,
  output logic [2*XW+NW-1:0]     sxx_o,
  output logic [2*YW+NW-1:0]     syy_o,
  output logic [XW+YW+NW-1:0]    sxy_o
);
  localparam int SXW  = XW + NW;
  localparam int SYW  = YW + NW;
  localparam int SXXW = 2 * XW + NW;
  localparam int SYYW = 2 * YW + NW;
  localparam int SXYW = XW + YW + NW;

  logic fresh;

  logic [SXXW-1:0] xx_term;
  logic [SYYW-1:0] yy_term;
  logic [SXYW-1:0] xy_term;

  assign xx_term = SXXW'(x_i) * SXXW'(x_i);
  assign yy_term = SYYW'(y_i) * SYYW'(y_i);
  assign xy_term = SXYW'(x_i) * SXYW'(y_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b1;
      n_o   <= '0;
      sx_o  <= '0;
      sy_o  <= '0;
      sxx_o <= '0;
      syy_o <= '0;
      sxy_o <= '0;
    end else if (clr_i) begin
      fresh <= 1'b1;
    end else if (beat_i) begin
      fresh <= 1'b0;
      if (fresh) begin
        n_o   <= NW'(1);
        sx_o  <= SXW'(x_i);
        sy_o  <= SYW'(y_i);
        sxx_o <= xx_term;
        syy_o <= yy_term;
        sxy_o <= xy_term;
      end else begin
        n_o   <= n_o + NW'(1);
        sx_o  <= sx_o + SXW'(x_i);
        sy_o  <= sy_o + SYW'(y_i);
        sxx_o <= sxx_o + xx_term;
        syy_o <= syy_o + yy_term;
        sxy_o <= sxy_o + xy_term;
      end
    end
  end

  assign empty_o = fresh;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !fresh && !clr_i) |-> (n_o != {NW{1'b1}})); // R3

  AST_FIRST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && fresh && !clr_i) |=> (n_o == NW'(1))); // R3
endmodule

// File: rtl/cmu_divider.sv
module cmu_divider #(
  parameter int DVW = 43,
  parameter int NW  = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [DVW-1:0] dividend_i,
  input  logic [NW-1:0]  divisor_i,
  output logic           done_o,
  output logic [DVW-1:0] quot_o
);
  localparam int CTW = $clog2(DVW + 1);

  logic [NW-1:0]  rem;
  logic [CTW-1:0] cnt;
  logic [NW:0]    rem_sh;
  logic           take;
  logic [NW:0]    rem_sub;

  assign rem_sh  = {rem, quot_o[DVW-1]};
  assign take    = (rem_sh >= {1'b0, divisor_i});
  assign rem_sub = rem_sh - {1'b0, divisor_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      cnt    <= '0;
      quot_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quot_o <= dividend_i;
        rem    <= '0;
        cnt    <= CTW'(DVW);
      end else if (cnt != '0) begin
        rem    <= take ? rem_sub[NW-1:0] : rem_sh[NW-1:0];
        quot_o <= {quot_o[DVW-2:0], take};
        cnt    <= cnt - CTW'(1);
        done_o <= (cnt == CTW'(1));
      end
    end
  end

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rem < divisor_i)); // R4

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (divisor_i != '0)); // R8
endmodule

// File: rtl/cmu_post.sv
module cmu_post
  import cmu_pkg::*;
#(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int NW   = 17,
  parameter int FRAC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        marker_i,
  input  logic                        empty_i,
  input  logic [NW-1:0]               n_i,
  input  logic [XW+NW-1:0]            sx_i,
  input  logic [YW+NW-1:0]            sy_i,
  input  logic [2*XW+NW-1:0]          sxx_i,
  input  logic [2*YW+NW-1:0]          syy_i,
  input  logic [XW+YW+NW-1:0]         sxy_i,
  output logic                        div_start_o,
  output logic [2*((XW > YW) ? XW : YW)+NW+FRAC-1:0] div_dividend_o,
  input  logic                        div_done_i,
  input  logic [2*((XW > YW) ? XW : YW)+NW+FRAC-1:0] div_quot_i,
  output logic                        in_ready_o,
  output logic                        clr_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [NW-1:0]               count_o,
  output logic [XW+FRAC-1:0]          mean_x_o,
  output logic [YW+FRAC-1:0]          mean_y_o,
  output logic [2*XW+FRAC-1:0]        mxx_o,
  output logic [2*YW+FRAC-1:0]        myy_o,
  output logic [XW+YW+FRAC:0]         mxy_o
);
  localparam int CW   = (XW > YW) ? XW : YW;
  localparam int DVW  = 2 * CW + NW + FRAC;
  localparam int MXW  = XW + FRAC;
  localparam int MYW  = YW + FRAC;
  localparam int VXW  = 2 * XW + FRAC;
  localparam int VYW  = 2 * YW + FRAC;
  localparam int EXYW = XW + YW + FRAC;
  localparam int CVW  = EXYW + 1;
  localparam logic [2:0] LAST_OP = 3'(NUM_DIV - 1);

  cmu_state_t state;
  logic [2:0] op;
  logic       go;

  logic [MXW-1:0]  q_mx;
  logic [MYW-1:0]  q_my;
  logic [VXW-1:0]  q_exx;
  logic [VYW-1:0]  q_eyy;
  logic [EXYW-1:0] q_exy;

  logic [VXW-1:0]  sq_xx;
  logic [VYW-1:0]  sq_yy;
  logic [EXYW-1:0] sq_xy;

  logic quot_fits;

  // Dividend selection: each raw sum is scaled by 2^FRAC before division.
  always_comb begin
    case (op)
      3'd0:    div_dividend_o = DVW'({sx_i,  {FRAC{1'b0}}});
      3'd1:    div_dividend_o = DVW'({sy_i,  {FRAC{1'b0}}});
      3'd2:    div_dividend_o = DVW'({sxx_i, {FRAC{1'b0}}});
      3'd3:    div_dividend_o = DVW'({syy_i, {FRAC{1'b0}}});
      3'd4:    div_dividend_o = DVW'({sxy_i, {FRAC{1'b0}}});
      default: div_dividend_o = '0;
    endcase
  end

  always_comb begin
    case (op)
      3'd0:    quot_fits = ((div_quot_i >> MXW)  == '0);
      3'd1:    quot_fits = ((div_quot_i >> MYW)  == '0);
      3'd2:    quot_fits = ((div_quot_i >> VXW)  == '0);
      3'd3:    quot_fits = ((div_quot_i >> VYW)  == '0);
      default: quot_fits = ((div_quot_i >> EXYW) == '0);
    endcase
  end

  assign div_start_o = go;
  assign in_ready_o  = (state == ST_ACC);
  assign clr_o       = (state == ST_OUT) && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_ACC;
      op          <= '0;
      go          <= 1'b0;
      q_mx        <= '0;
      q_my        <= '0;
      q_exx       <= '0;
      q_eyy       <= '0;
      q_exy       <= '0;
      sq_xx       <= '0;
      sq_yy       <= '0;
      sq_xy       <= '0;
      out_valid_o <= 1'b0;
      count_o     <= '0;
      mean_x_o    <= '0;
      mean_y_o    <= '0;
      mxx_o       <= '0;
      myy_o       <= '0;
      mxy_o       <= '0;
    end else begin
      go <= 1'b0;
      case (state)
        ST_ACC: begin
          if (marker_i && !empty_i) begin
            state <= ST_DIV;
            op    <= '0;
            go    <= 1'b1;
          end
        end
        ST_DIV: begin
          if (div_done_i) begin
            case (op)
              3'd0:    q_mx  <= div_quot_i[MXW-1:0];
              3'd1:    q_my  <= div_quot_i[MYW-1:0];
              3'd2:    q_exx <= div_quot_i[VXW-1:0];
              3'd3:    q_eyy <= div_quot_i[VYW-1:0];
              default: q_exy <= div_quot_i[EXYW-1:0];
            endcase
            if (op == LAST_OP) begin
              state <= ST_SQ;
            end else begin
              op <= op + 3'd1;
              go <= 1'b1;
            end
          end
        end
        ST_SQ: begin
          // Means are squared once here and reused by the subtract stage.
          sq_xx <= VXW'(({{MXW{1'b0}}, q_mx} * {{MXW{1'b0}}, q_mx}) >> FRAC);
          sq_yy <= VYW'(({{MYW{1'b0}}, q_my} * {{MYW{1'b0}}, q_my}) >> FRAC);
          sq_xy <= EXYW'(({{MYW{1'b0}}, q_mx} * {{MXW{1'b0}}, q_my}) >> FRAC);
          state <= ST_SUB;
        end
        ST_SUB: begin
          count_o     <= n_i;
          mean_x_o    <= q_mx;
          mean_y_o    <= q_my;
          mxx_o       <= q_exx - sq_xx;
          myy_o       <= q_eyy - sq_yy;
          mxy_o       <= CVW'($signed({1'b0, q_exy}) - $signed({1'b0, sq_xy}));
          out_valid_o <= 1'b1;
          state       <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready_i) begin
            out_valid_o <= 1'b0;
            state       <= ST_ACC;
          end
        end
        default: state <= ST_ACC;
      endcase
    end
  end

  AST_QUOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV && div_done_i) |-> quot_fits); // R4

  AST_MOMENT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUB) |-> ((q_exx >= sq_xx) && (q_eyy >= sq_yy))); // R5

  AST_DIV_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    div_done_i |-> (state == ST_DIV)); // R9
endmodule

// File: rtl/contour_moment_unit.sv
module contour_moment_unit #(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int NW   = 17,
  parameter int FRAC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [XW-1:0]            in_x,
  input  logic [YW-1:0]            in_y,
  input  logic                     in_last,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NW-1:0]            out_count,
  output logic [XW+FRAC-1:0]       out_mean_x,
  output logic [YW+FRAC-1:0]       out_mean_y,
  output logic [2*XW+FRAC-1:0]     out_mxx,
  output logic [2*YW+FRAC-1:0]     out_myy,
  output logic [XW+YW+FRAC:0]      out_mxy
);
  localparam int CW  = (XW > YW) ? XW : YW;
  localparam int DVW = 2 * CW + NW + FRAC;

  logic                  beat;
  logic                  marker;
  logic                  clr;
  logic                  empty;
  logic [NW-1:0]         n_cnt;
  logic [XW+NW-1:0]      sum_x;
  logic [YW+NW-1:0]      sum_y;
  logic [2*XW+NW-1:0]    sum_xx;
  logic [2*YW+NW-1:0]    sum_yy;
  logic [XW+YW+NW-1:0]   sum_xy;
  logic                  div_start;
  logic                  div_done;
  logic [DVW-1:0]        div_dividend;
  logic [DVW-1:0]        div_quot;

  assign beat   = in_valid && in_ready && !in_last;
  assign marker = in_valid && in_ready && in_last;

  cmu_accum #(.XW(XW), .YW(YW), .NW(NW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_i  (beat),
    .clr_i   (clr),
    .x_i     (in_x),
    .y_i     (in_y),
    .empty_o (empty),
    .n_o     (n_cnt),
    .sx_o    (sum_x),
    .sy_o    (sum_y),
    .sxx_o   (sum_xx),
    .syy_o   (sum_yy),
    .sxy_o   (sum_xy)
  );

  cmu_divider #(.DVW(DVW), .NW(NW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (n_cnt),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  cmu_post #(.XW(XW), .YW(YW), .NW(NW), .FRAC(FRAC)) u_post (
    .clk            (clk),
    .rst_n          (rst_n),
    .marker_i       (marker),
    .empty_i        (empty),
    .n_i            (n_cnt),
    .sx_i           (sum_x),
    .sy_i           (sum_y),
    .sxx_i          (sum_xx),
    .syy_i          (sum_yy),
    .sxy_i          (sum_xy),
    .div_start_o    (div_start),
    .div_dividend_o (div_dividend),
    .div_done_i     (div_done),
    .div_quot_i     (div_quot),
    .in_ready_o     (in_ready),
    .clr_o          (clr),
    .out_valid_o    (out_valid),
    .out_ready_i    (out_ready),
    .count_o        (out_count),
    .mean_x_o       (out_mean_x),
    .mean_y_o       (out_mean_y),
    .mxx_o          (out_mxx),
    .myy_o          (out_myy),
    .mxy_o          (out_mxy)
  );

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1

  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (marker && empty) |=> (in_ready && !out_valid)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count) && $stable(out_mean_x)
      && $stable(out_mean_y) && $stable(out_mxx) && $stable(out_myy) && $stable(out_mxy))); // R10

  AST_SINGLE_PIXEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == NW'(1)) |-> (out_mxx == '0 && out_myy == '0 && out_mxy == '0)); // R7

  AST_MARKER_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (marker && !empty) |=> $stable(n_cnt)); // R2
endmodule

// File: tb/contour_moment_unit_bench.sv
module contour_moment_unit_bench;
  localparam int  XW     = 9;
  localparam int  YW     = 8;
  localparam int  NW     = 17;
  localparam int  FRAC   = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  XMAX   = 383;
  localparam int  YMAX   = 239;
  localparam int  CWB    = (XW > YW) ? XW : YW;
  localparam int  DIVW   = 2 * CWB + NW + FRAC;
  localparam int  LAT    = 5 * (DIVW + 2) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NW-1:0] out_count;
  logic [XW+FRAC-1:0] out_mean_x;
  logic [YW+FRAC-1:0] out_mean_y;
  logic [2*XW+FRAC-1:0] out_mxx;
  logic [2*YW+FRAC-1:0] out_myy;
  logic [XW+YW+FRAC:0] out_mxy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  contour_moment_unit #(.XW(XW), .YW(YW), .NW(NW), .FRAC(FRAC)) u_contour_moment_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
    .out_mean_x(out_mean_x), .out_mean_y(out_mean_y),
    .out_mxx(out_mxx), .out_myy(out_myy), .out_mxy(out_mxy)
  );

  typedef struct {
    longint n, mx, my, vxx, vyy, cxy;
  } exp_t;

  exp_t exp_q[$];
  int tests = 0;
  int fails = 0;
  bit model_on = 1'b0;
  bit stim_done = 1'b0;
  bit out_phase_free = 1'b0;

  // reference model state
  bit     m_fresh = 1'b1;
  longint m_n, m_sx, m_sy, m_sxx, m_syy, m_sxy;
  bit     exp_ready = 1'b1;
  bit     exp_outv = 1'b0;
  int     lat_cnt = 0;
  bit     prev_hold = 1'b0;
  logic [95:0] prev_bus;

  function automatic exp_t compute(longint n, longint sx, longint sy,
                                   longint sxx, longint syy, longint sxy);
    exp_t e;
    longint exx, eyy, exy;
    e.n   = n;
    e.mx  = (sx << FRAC) / n;
    e.my  = (sy << FRAC) / n;
    exx   = (sxx << FRAC) / n;
    eyy   = (syy << FRAC) / n;
    exy   = (sxy << FRAC) / n;
    e.vxx = exx - ((e.mx * e.mx) >> FRAC);
    e.vyy = eyy - ((e.my * e.my) >> FRAC);
    e.cxy = exy - ((e.mx * e.my) >> FRAC);
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // Per-clock comparison and model update, away from the active edge.
  always @(negedge clk) begin
    if (model_on) begin
      logic [95:0] bus;
      bus = {out_count, out_mean_x, out_mean_y, out_mxx, out_myy, out_mxy};
      check(in_ready == exp_ready, "R1", "in_ready", longint'(in_ready), longint'(exp_ready));
      check(out_valid == exp_outv, "R9", "out_valid timing", longint'(out_valid), longint'(exp_outv));
      if (prev_hold)
        check(bus == prev_bus && out_valid, "R10", "hold under back-pressure",
              longint'(bus[63:0]), longint'(prev_bus[63:0]));
      prev_hold = out_valid && !out_ready;
      prev_bus  = bus;

      if (out_valid && exp_outv && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q[0];
        check(longint'(out_count) == e.n, "R3", "count", longint'(out_count), e.n);
        check(longint'(out_mean_x) == e.mx, "R4", "mean_x", longint'(out_mean_x), e.mx);
        check(longint'(out_mean_y) == e.my, "R4", "mean_y", longint'(out_mean_y), e.my);
        check(longint'(out_mxx) == e.vxx, "R5", "mxx", longint'(out_mxx), e.vxx);
        check(longint'(out_myy) == e.vyy, "R5", "myy", longint'(out_myy), e.vyy);
        check(longint'($signed(out_mxy)) == e.cxy, "R6", "mxy",
              longint'($signed(out_mxy)), e.cxy);
        if (e.n == 1)
          check(out_mxx == '0 && out_myy == '0 && out_mxy == '0, "R7", "single pixel moments",
                longint'(out_mxx) + longint'(out_myy) + longint'(out_mxy), 0);
      end

      // predictions for the next cycle
      if (exp_outv && out_ready) begin
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        exp_outv  = 1'b0;
        exp_ready = 1'b1;
        prev_hold = 1'b0;
      end
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) exp_outv = 1'b1;
      end
      if (in_valid && in_ready) begin
        if (in_last) begin
          if (!m_fresh) begin
            exp_q.push_back(compute(m_n, m_sx, m_sy, m_sxx, m_syy, m_sxy));
            exp_ready = 1'b0;
            lat_cnt   = LAT;
            m_fresh   = 1'b1;
          end
          // R8: an empty marker leaves the model untouched
        end else begin
          longint x, y;
          x = longint'(in_x);
          y = longint'(in_y);
          if (m_fresh) begin
            m_n = 1; m_sx = x; m_sy = y; m_sxx = x * x; m_syy = y * y; m_sxy = x * y;
          end else begin
            m_n++; m_sx += x; m_sy += y; m_sxx += x * x; m_syy += y * y; m_sxy += x * y;
          end
          m_fresh = 1'b0;
        end
      end
    end
  end

  task automatic send_beat(int x, int y, bit last);
    in_valid = 1'b1;
    in_x     = XW'(x);
    in_y     = YW'(y);
    in_last  = last;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (($urandom % 3) == 0) begin
      repeat ($urandom % 3) @(posedge clk);
      #1;
    end
  endtask

  // kind 0 random, 1 far corner, 2 repeated point
  task automatic send_contour(int len, int kind);
    int px, py;
    px = $urandom % (XMAX + 1);
    py = $urandom % (YMAX + 1);
    for (int i = 0; i < len; i++) begin
      if (kind == 0) send_beat($urandom % (XMAX + 1), $urandom % (YMAX + 1), 1'b0);
      else if (kind == 1) send_beat(XMAX - (i % 2), YMAX - (i % 3), 1'b0);
      else send_beat(px, py, 1'b0);
    end
    // R2: marker carries random coordinates that must be ignored
    send_beat($urandom % 512, $urandom % 256, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = out_phase_free ? 1'b1 : (($urandom % 4) != 0);
    end
  end

  initial begin
    void'($urandom(7));
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R9", "reset out_valid", longint'(out_valid), 0);
    @(posedge clk);
    #1;
    model_on = 1'b1;

    send_contour(1, 0);        // R7 single pixel
    send_beat(5, 5, 1'b1);     // R8 empty marker
    send_beat(100, 20, 1'b1);  // R8 second empty marker in a row
    send_contour(2, 0);
    send_contour(3, 2);        // repeated point, zero moments
    send_contour(1, 1);        // R7 at far corner
    send_contour(300, 1);      // widest sums
    out_phase_free = 1'b1;
    send_contour(7, 0);
    send_contour(1, 2);
    out_phase_free = 1'b0;
    for (int k = 0; k < 20; k++) begin
      send_contour(1 + ($urandom % 40), 0);
      if ((k % 5) == 0) send_beat(0, 0, 1'b1);  // R8 interleaved empty marker
    end
    send_contour(120, 0);

    stim_done = 1'b1;
    while (exp_q.size() > 0 || lat_cnt > 0 || exp_outv) @(posedge clk);
    repeat (5) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule